// File: doc/BRIEF.md
# Grid Connection and Protection Sequencer

This block decides when the inverter bridge may switch and which parts of the output control are active. With no connection, the bridge is held off. Grid sensing and phase tracking elsewhere in the system keep running. A connect request is accepted only while the grid looks present, meaning its voltage and its frequency both sit inside their windows. The sequencer then waits for the rollover pulse of the local oscillator, which marks a grid zero crossing. On that pulse it enables the bridge at zero duty and starts feedforward tracking of the grid voltage.

The isolated current sensor draws its supply from the switching itself, so its readings are not usable until a settle interval has passed after the bridge starts. A cycle counter times this interval. When it ends, the block enables PI current control alongside feedforward.

While connected, the block compares five measured quantities against limits supplied on ports: grid voltage, grid frequency, DC bus voltage, output current and current-tracking error. The first breach turns everything off and latches a code that names the quantity. The code stays until an explicit clear. After the clear, a fresh connect request is needed before the block will connect again.

Top module: `grid_link_sequencer`

## Requirements
- R1: After reset, `bridge_en`, `ff_en` and `pi_en` are low and `fault_code` is 0.
- R2: A rising edge of `connect_req`, with the grid present, arms the sequencer. The bridge stays off until `lo_wrap` is sampled high. In the cycle after that sample, `bridge_en` and `ff_en` are high and `pi_en` is low.
- R3: `pi_en` rises exactly `SETTLE_CYCLES` clock cycles after `bridge_en` rises. The settle count restarts from zero on every new connection.
- R4: A request made while grid voltage or grid frequency is outside its window is ignored. An armed sequencer whose grid leaves its window returns to idle without a fault, and it needs a new request edge to arm again.
- R5: While connected, a breach of any checked quantity turns `bridge_en`, `ff_en` and `pi_en` off in the next cycle and latches `fault_code` as follows: 1 = grid voltage, 2 = grid frequency, 3 = DC bus voltage, 4 = output current, 5 = current error.
- R6: When several quantities breach in the same cycle, the lowest code among them is latched.
- R7: A latched code holds until `fault_clear` is sampled high, which returns it to 0. `fault_clear` has no effect when no fault is latched. After a clear, the bridge stays off until a new rising edge of `connect_req`.
- R8: Dropping `connect_req` while connected turns all enables off in the next cycle and latches no fault.
- R9: While disconnected (idle or armed), breaches of DC bus voltage, output current and current error are ignored. They latch no fault and do not prevent connection.
- R10: Windows include their bounds, so a value equal to a limit is not a breach. Output current and current error are checked against ±(magnitude limit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| connect_req | input | 1 | Request to join the grid (rising edge arms) |
| fault_clear | input | 1 | Clears a latched fault |
| lo_wrap | input | 1 | Oscillator index rollover pulse (zero crossing) |
| grid_v | input | DW | Measured grid voltage, signed |
| grid_f | input | DW | Measured grid frequency, signed |
| bus_v | input | DW | Measured DC bus voltage, signed |
| out_i | input | DW | Measured output current, signed |
| i_err | input | DW | Current tracking error, signed |
| grid_v_min | input | DW | Lower grid voltage bound |
| grid_v_max | input | DW | Upper grid voltage bound |
| grid_f_min | input | DW | Lower grid frequency bound |
| grid_f_max | input | DW | Upper grid frequency bound |
| bus_v_min | input | DW | Lower bus voltage bound |
| bus_v_max | input | DW | Upper bus voltage bound |
| out_i_lim | input | DW | Output current magnitude limit |
| i_err_lim | input | DW | Current error magnitude limit |
| bridge_en | output | 1 | Bridge switching enable |
| ff_en | output | 1 | Feedforward voltage tracking enable |
| pi_en | output | 1 | PI current control enable |
| fault_code | output | 3 | Latched code of the first breach, 0 when none |

## Verification
The hardest situation to reach is a return from a latched fault while `connect_req` is still held high. Since only an edge arms the block, the bench keeps the request asserted through the breach, the clear and several later cycles, then confirms the bridge stays off. A second hard case is a grid that drops out after arming but before the rollover pulse. The bench gets there by raising the request, moving the frequency outside its window for a single cycle, restoring it, and only then pulsing `lo_wrap`.

// File: rtl/gls_pkg.sv
package gls_pkg;

    localparam int NUM_CHK = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SETTLE,
        ST_RUN,
        ST_TRIP
    } link_state_e;

    typedef enum logic [2:0] {
        FC_NONE   = 3'd0,
        FC_GRID_V = 3'd1,
        FC_GRID_F = 3'd2,
        FC_BUS_V  = 3'd3,
        FC_OUT_I  = 3'd4,
        FC_I_ERR  = 3'd5
    } fault_code_e;

    // Lowest index wins: scan from high to low so the last write is the lowest.
    function automatic fault_code_e first_breach(input logic [NUM_CHK-1:0] b);
        fault_code_e code;
        code = FC_NONE;
        for (int i = NUM_CHK - 1; i >= 0; i--) begin
            if (b[i]) code = fault_code_e'(3'(i + 1));
        end
        return code;
    endfunction

    function automatic logic is_connected(input link_state_e s);
        return (s == ST_SETTLE) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/gls_window_chk.sv
module gls_window_chk #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] value,
    input  logic signed [DW-1:0] lo,
    input  logic signed [DW-1:0] hi,
    output logic                 breach
);
    // Bounds are inclusive: equality with a bound is inside the window.
    always_comb breach = (value < lo) || (value > hi);
endmodule

// File: rtl/gls_settle_timer.sv
module gls_settle_timer #(
    parameter int CYCLES = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    always_comb done = run && (cnt == LAST);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    p_cnt_restart_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
endmodule

// File: rtl/gls_link_fsm.sv
module gls_link_fsm
    import gls_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               connect_req,
    input  logic               fault_clear,
    input  logic               lo_wrap,
    input  logic [NUM_CHK-1:0] breach,
    input  logic               settle_done,
    output link_state_e        state,
    output fault_code_e        code
);
    link_state_e nxt;
    logic        req_q;
    logic        req_rise;
    logic        grid_ok;
    logic        any_breach;

    always_comb begin
        req_rise   = connect_req && !req_q;
        grid_ok    = !breach[0] && !breach[1];
        any_breach = |breach;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_rise && grid_ok) nxt = ST_ARMED;
            ST_ARMED:  if (!connect_req || !grid_ok) nxt = ST_IDLE;
                       else if (lo_wrap) nxt = ST_SETTLE;
            ST_SETTLE: if (any_breach) nxt = ST_TRIP;
                       else if (!connect_req) nxt = ST_IDLE;
                       else if (settle_done) nxt = ST_RUN;
            ST_RUN:    if (any_breach) nxt = ST_TRIP;
                       else if (!connect_req) nxt = ST_IDLE;
            ST_TRIP:   if (fault_clear) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            code  <= FC_NONE;
            req_q <= 1'b0;
        end else begin
            state <= nxt;
            req_q <= connect_req;
            if (is_connected(state) && any_breach) code <= first_breach(breach);
            else if (state == ST_TRIP && fault_clear) code <= FC_NONE;
        end
    end

    p_trip_next_r5: assert property (@(posedge clk) disable iff (rst)
        (is_connected(state) && any_breach) |=> state == ST_TRIP);
    p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (code != FC_NONE && !fault_clear) |=> code == $past(code));
    p_grid_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !grid_ok) |=> state != ST_ARMED);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!is_connected(state) && state != ST_TRIP) |=> code == FC_NONE);
endmodule

// File: rtl/grid_link_sequencer.sv
module grid_link_sequencer
    import gls_pkg::*;
#(
    parameter int DW            = 16,
    parameter int SETTLE_CYCLES = 200000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 connect_req,
    input  logic                 fault_clear,
    input  logic                 lo_wrap,
    input  logic signed [DW-1:0] grid_v,
    input  logic signed [DW-1:0] grid_f,
    input  logic signed [DW-1:0] bus_v,
    input  logic signed [DW-1:0] out_i,
    input  logic signed [DW-1:0] i_err,
    input  logic signed [DW-1:0] grid_v_min,
    input  logic signed [DW-1:0] grid_v_max,
    input  logic signed [DW-1:0] grid_f_min,
    input  logic signed [DW-1:0] grid_f_max,
    input  logic signed [DW-1:0] bus_v_min,
    input  logic signed [DW-1:0] bus_v_max,
    input  logic signed [DW-1:0] out_i_lim,
    input  logic signed [DW-1:0] i_err_lim,
    output logic                 bridge_en,
    output logic                 ff_en,
    output logic                 pi_en,
    output logic [2:0]           fault_code
);
    logic signed [DW-1:0] chk_val [NUM_CHK];
    logic signed [DW-1:0] chk_lo  [NUM_CHK];
    logic signed [DW-1:0] chk_hi  [NUM_CHK];
    logic [NUM_CHK-1:0]   breach;
    link_state_e          state;
    fault_code_e          code;
    logic                 settle_done;

    // Order of the checks sets the fault code and its priority.
    always_comb begin
        chk_val[0] = grid_v; chk_lo[0] = grid_v_min; chk_hi[0] = grid_v_max;
        chk_val[1] = grid_f; chk_lo[1] = grid_f_min; chk_hi[1] = grid_f_max;
        chk_val[2] = bus_v;  chk_lo[2] = bus_v_min;  chk_hi[2] = bus_v_max;
        chk_val[3] = out_i;  chk_lo[3] = -out_i_lim; chk_hi[3] = out_i_lim;
        chk_val[4] = i_err;  chk_lo[4] = -i_err_lim; chk_hi[4] = i_err_lim;
    end

    for (genvar g = 0; g < NUM_CHK; g++) begin : g_chk
        gls_window_chk #(.DW(DW)) u_chk (
            .value  (chk_val[g]),
            .lo     (chk_lo[g]),
            .hi     (chk_hi[g]),
            .breach (breach[g])
        );
    end

    gls_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_SETTLE),
        .done (settle_done)
    );

    gls_link_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .connect_req (connect_req),
        .fault_clear (fault_clear),
        .lo_wrap     (lo_wrap),
        .breach      (breach),
        .settle_done (settle_done),
        .state       (state),
        .code        (code)
    );

    always_comb begin
        bridge_en  = is_connected(state);
        ff_en      = is_connected(state);
        pi_en      = (state == ST_RUN);
        fault_code = code;
    end

    p_pi_inside_bridge_r3: assert property (@(posedge clk) disable iff (rst)
        pi_en |-> (bridge_en && ff_en));
    p_connect_on_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bridge_en) |-> ($past(lo_wrap) && !pi_en));
    p_fault_off_r5: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 3'd0) |-> !bridge_en);
    p_req_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (!connect_req) |=> !bridge_en);
endmodule

// File: tb/sim_grid_link_sequencer.sv
module sim_grid_link_sequencer;
    localparam int DW = 16;
    localparam int N  = 20;

    typedef struct packed {
        logic [2:0]           idx;
        logic signed [DW-1:0] val;
        logic [2:0]           code;
    } vec_t;

    // R5 stimulus table: quantity index, offending value, expected code.
    localparam vec_t VECS [8] = '{
        '{3'd0, 16'sd199,  3'd1},
        '{3'd0, 16'sd261,  3'd1},
        '{3'd1, 16'sd521,  3'd2},
        '{3'd2, 16'sd349,  3'd3},
        '{3'd3, 16'sd101,  3'd4},
        '{3'd3, -16'sd101, 3'd4},
        '{3'd4, -16'sd51,  3'd5},
        '{3'd4, 16'sd51,   3'd5}
    };

    logic clk = 1'b0;
    logic rst, connect_req, fault_clear, lo_wrap;
    logic signed [DW-1:0] grid_v, grid_f, bus_v, out_i, i_err;
    logic bridge_en, ff_en, pi_en;
    logic [2:0] fault_code;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    grid_link_sequencer #(.DW(DW), .SETTLE_CYCLES(N)) u0 (
        .clk(clk), .rst(rst), .connect_req(connect_req), .fault_clear(fault_clear),
        .lo_wrap(lo_wrap), .grid_v(grid_v), .grid_f(grid_f), .bus_v(bus_v),
        .out_i(out_i), .i_err(i_err),
        .grid_v_min(16'sd200), .grid_v_max(16'sd260),
        .grid_f_min(16'sd470), .grid_f_max(16'sd520),
        .bus_v_min(16'sd350), .bus_v_max(16'sd450),
        .out_i_lim(16'sd100), .i_err_lim(16'sd50),
        .bridge_en(bridge_en), .ff_en(ff_en), .pi_en(pi_en), .fault_code(fault_code)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic nominal();
        grid_v = 16'sd230; grid_f = 16'sd500; bus_v = 16'sd400;
        out_i = 16'sd0; i_err = 16'sd0;
    endtask

    task automatic set_q(input logic [2:0] idx, input logic signed [DW-1:0] v);
        case (idx)
            3'd0: grid_v = v;
            3'd1: grid_f = v;
            3'd2: bus_v = v;
            3'd3: out_i = v;
            default: i_err = v;
        endcase
    endtask

    // Fresh request, wait for rollover, settle, reach full control.
    task automatic go_run();
        connect_req = 1'b0; step(1);
        connect_req = 1'b1; step(1);
        chk("R2 armed bridge off", bridge_en, 0);
        step(3);
        chk("R2 no wrap yet bridge off", bridge_en, 0);
        lo_wrap = 1'b1; step(1); lo_wrap = 1'b0;
        chk("R2 bridge on at wrap", bridge_en, 1);
        chk("R2 ff on at wrap", ff_en, 1);
        chk("R2 pi off at wrap", pi_en, 0);
        step(N - 1);
        chk("R3 pi still off", pi_en, 0);
        step(1);
        chk("R3 pi on after settle", pi_en, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; connect_req = 1'b0; fault_clear = 1'b0; lo_wrap = 1'b0;
        nominal();
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 bridge", bridge_en, 0);
        chk("R1 ff", ff_en, 0);
        chk("R1 pi", pi_en, 0);
        chk("R1 code", fault_code, 0);

        go_run();

        // R10: values exactly at the bounds are inside.
        grid_v = 16'sd260; grid_f = 16'sd470; bus_v = 16'sd450;
        out_i = -16'sd100; i_err = 16'sd50;
        step(2);
        chk("R10 at bounds still connected", bridge_en, 1);
        chk("R10 at bounds no code", fault_code, 0);
        nominal();

        // R7: clear has no effect without a fault.
        fault_clear = 1'b1; step(1); fault_clear = 1'b0; step(1);
        chk("R7 idle clear keeps bridge", bridge_en, 1);
        chk("R7 idle clear keeps code", fault_code, 0);

        // R8: dropping the request disconnects cleanly.
        connect_req = 1'b0; step(1);
        chk("R8 bridge off", bridge_en, 0);
        chk("R8 pi off", pi_en, 0);
        chk("R8 no code", fault_code, 0);

        for (int k = 0; k < 8; k++) begin
            go_run();
            set_q(VECS[k].idx, VECS[k].val);
            step(1);
            chk("R5 bridge off on breach", bridge_en, 0);
            chk("R5 ff off on breach", ff_en, 0);
            chk("R5 code", fault_code, VECS[k].code);
            nominal(); step(2);
            chk("R7 code held", fault_code, VECS[k].code);
            fault_clear = 1'b1; step(1); fault_clear = 1'b0;
            chk("R7 code cleared", fault_code, 0);
            lo_wrap = 1'b1; step(1); lo_wrap = 1'b0; step(2);
            chk("R7 held request does not reconnect", bridge_en, 0);
        end

        // R6: simultaneous breach reports the lowest code.
        go_run();
        grid_f = 16'sd600; out_i = 16'sd500; i_err = 16'sd300;
        step(1);
        chk("R6 lowest code wins", fault_code, 2);
        nominal();
        fault_clear = 1'b1; step(1); fault_clear = 1'b0;

        // R4: request with grid absent is ignored.
        connect_req = 1'b0; step(1);
        grid_v = 16'sd150; connect_req = 1'b1; step(1);
        lo_wrap = 1'b1; step(1); lo_wrap = 1'b0;
        chk("R4 no connect without grid", bridge_en, 0);
        grid_v = 16'sd230; step(1);
        lo_wrap = 1'b1; step(1); lo_wrap = 1'b0;
        chk("R4 no connect without new edge", bridge_en, 0);
        // R4: armed, grid frequency leaves window briefly.
        connect_req = 1'b0; step(1); connect_req = 1'b1; step(1);
        grid_f = 16'sd400; step(1); grid_f = 16'sd500; step(1);
        lo_wrap = 1'b1; step(1); lo_wrap = 1'b0;
        chk("R4 disarmed by grid loss", bridge_en, 0);
        chk("R4 grid loss no code", fault_code, 0);

        // R9: other checks ignored while armed.
        connect_req = 1'b0; step(1); connect_req = 1'b1; step(1);
        bus_v = 16'sd600; out_i = 16'sd900; i_err = -16'sd400;
        step(3);
        chk("R9 no fault while armed", fault_code, 0);
        chk("R9 bridge off while armed", bridge_en, 0);
        nominal();
        lo_wrap = 1'b1; step(1); lo_wrap = 1'b0;
        chk("R9 still connects", bridge_en, 1);

        // R3: abort mid-settle, then a full settle from zero.
        step(5);
        connect_req = 1'b0; step(1);
        chk("R3 abort settle", bridge_en, 0);
        go_run();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule